// File: doc/BRIEF.md
# Sync-Marked Code-Block Serial Framer

This block assembles the transmit packets of a block-coded serial telemetry link. Payload bits arrive one at a time on a valid/ready input and are gathered into fixed-size blocks. The parity bits for each block come from a separate upstream encoder port, also on a valid/ready handshake. For every block the framer sends a 256-bit sync marker, then the buffered payload in arrival order, then the parity bits, as one serial stream. The marker has four 64-bit sub-words: a base word, the same word again, its bitwise complement, and the base word once more. Each sub-word is sent most significant bit first.

The output advances one bit for each cycle in which the downstream bit clock (`out_ready`) is high. Payload is held in two alternating block banks. A new block can therefore be accepted while the previous one is still being sent. At the nominal output-to-input rate ratio of 25/16 (6400/4096), packets follow one another with no idle bits between them. The block never drops input. It only stalls the input when both banks hold blocks that have not yet been sent.

A packet starts only when a whole block is buffered. Once the parity section has begun, a parity bit that is not ready in time stalls the stream and raises an underrun flag for that cycle.

Top module: `sync_block_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_sop` and `underrun` are 0, `out_tag` is 0, `in_ready` is 1 and `par_ready` is 0.
- R2: Each packet is sent as 4*SUB_BITS marker bits, then PAY_BITS payload bits in the order they were accepted, then PAR_BITS parity bits, each parity bit equal to `par_bit` at its transfer.
- R3: Marker bit k is bit (SUB_BITS-1 - k mod SUB_BITS) of MARK_SUB, inverted when k div SUB_BITS equals 2. With the default word the stream begins 1111110010111000.
- R4: `out_sop` is 1 exactly in cycles where the first marker bit of a packet is presented.
- R5: `out_tag` is 0 when idle, 1 on marker bits, 2 on payload bits and 3 on parity bits.
- R6: The output only advances in cycles with `out_valid` and `out_ready` both high. Otherwise the marker or payload bit, the tag and the position are held.
- R7: `par_ready` is 1 only during the parity section while `out_ready` is 1. `out_valid` follows `par_valid` there.
- R8: `underrun` is 1 exactly in cycles of the parity section where `out_ready` is 1 and `par_valid` is 0. The position does not advance in such a cycle.
- R9: `in_ready` is 0 only when two complete blocks are held and not yet fully sent. No accepted payload bit is lost or reordered.
- R10: If the next block is complete no later than the cycle in which the last parity bit of a packet is sent, the next marker starts in the following cycle, with no invalid cycle between.
- R11: No packet starts before a complete block is buffered. Until then `out_valid` is 0 and `out_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | Payload bit |
| in_valid | input | 1 | Payload bit offered |
| in_ready | output | 1 | Payload bit accepted when high with in_valid |
| par_bit | input | 1 | Parity bit from encoder |
| par_valid | input | 1 | Parity bit offered |
| par_ready | output | 1 | Parity bit taken when high with par_valid |
| out_ready | input | 1 | Downstream bit clock enable |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | out_bit is meaningful |
| out_sop | output | 1 | First marker bit of a packet |
| out_tag | output | 2 | Section of the current bit: 0 idle, 1 marker, 2 payload, 3 parity |
| underrun | output | 1 | Parity bit needed but absent this cycle |

## Verification
The bench builds the framer with PAY_BITS=16, PAR_BITS=8 and WORD_BITS=4, and keeps the full 64-bit marker sub-word. A packet is then 280 bits long. This allows many packets in one run, so bank swaps, both banks filling up and input stalls all occur often. Keeping the full-length default marker lets the bench check the exact opening bit pattern. The short blocks also let random bit-clock and parity gaps land on section boundaries, the last payload bit and the last parity bit.

// File: rtl/sync_block_framer.sv
module sync_block_framer #(
  parameter int PAY_BITS  = 4096,
  parameter int PAR_BITS  = 2048,
  parameter int SUB_BITS  = 64,
  parameter int WORD_BITS = 64,
  parameter logic [SUB_BITS-1:0] MARK_SUB = 64'hFCB88938D8D76A4F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_bit,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       par_bit,
  input  logic       par_valid,
  output logic       par_ready,
  input  logic       out_ready,
  output logic       out_bit,
  output logic       out_valid,
  output logic       out_sop,
  output logic [1:0] out_tag,
  output logic       underrun
);

  localparam int MARK_BITS = 4 * SUB_BITS;
  localparam int WPB       = PAY_BITS / WORD_BITS;
  localparam int DEPTH     = 2 * WPB;
  localparam int AW        = $clog2(DEPTH);
  localparam int LW        = $clog2(WORD_BITS);
  localparam int LS        = $clog2(SUB_BITS);
  localparam int PMAX1     = (PAY_BITS > PAR_BITS) ? PAY_BITS : PAR_BITS;
  localparam int POS_MAX   = (PMAX1 > MARK_BITS) ? PMAX1 : MARK_BITS;
  localparam int CW        = $clog2(POS_MAX);

  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_MARK = 2'd1;
  localparam logic [1:0] PH_PAY  = 2'd2;
  localparam logic [1:0] PH_PAR  = 2'd3;

  logic [WORD_BITS-1:0] mem [DEPTH];
  logic [WORD_BITS-1:0] wsh;
  logic [CW-1:0] wcnt, pos;
  logic [1:0] phase, bank_full, full_nxt;
  logic wr_bank, rd_bank;
  logic accept, w_last, word_done, adv, release_blk;
  logic mark_bit, pay_bit;
  logic [AW-1:0] waddr, raddr;

  assign in_ready  = ~bank_full[wr_bank];
  assign accept    = in_valid & in_ready;
  assign w_last    = accept && (wcnt == CW'(PAY_BITS - 1));
  assign word_done = accept && (&wcnt[LW-1:0]);
  assign waddr     = AW'(wr_bank ? WPB : 0) + AW'(wcnt >> LW);
  assign raddr     = AW'(rd_bank ? WPB : 0) + AW'(pos >> LW);

  assign pay_bit  = mem[raddr][~pos[LW-1:0]];
  assign mark_bit = MARK_SUB[~pos[LS-1:0]] ^ (pos[LS+1:LS] == 2'd2);

  assign out_tag   = phase;
  assign out_valid = (phase == PH_MARK) | (phase == PH_PAY) | ((phase == PH_PAR) & par_valid);
  assign out_bit   = (phase == PH_MARK) ? mark_bit :
                     (phase == PH_PAY)  ? pay_bit  :
                     (phase == PH_PAR)  ? par_bit  : 1'b0;
  assign out_sop   = (phase == PH_MARK) && (pos == '0);
  assign par_ready = (phase == PH_PAR) & out_ready;
  assign underrun  = (phase == PH_PAR) & out_ready & ~par_valid;
  assign adv       = out_valid & out_ready;
  assign release_blk = (phase == PH_PAY) && adv && (pos == CW'(PAY_BITS - 1));

  always_comb begin
    full_nxt = bank_full;
    if (w_last)      full_nxt[wr_bank] = 1'b1;
    if (release_blk) full_nxt[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (word_done) mem[waddr] <= {wsh[WORD_BITS-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsh       <= '0;
      wcnt      <= '0;
      wr_bank   <= 1'b0;
      bank_full <= 2'b00;
    end else begin
      bank_full <= full_nxt;
      if (accept) begin
        wsh <= {wsh[WORD_BITS-2:0], in_bit};
        if (w_last) begin
          wcnt    <= '0;
          wr_bank <= ~wr_bank;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      pos     <= '0;
      rd_bank <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (bank_full[rd_bank]) begin
          phase <= PH_MARK;
          pos   <= '0;
        end
        PH_MARK: if (adv) begin
          if (pos == CW'(MARK_BITS - 1)) begin
            phase <= PH_PAY;
            pos   <= '0;
          end else pos <= pos + 1'b1;
        end
        PH_PAY: if (adv) begin
          if (release_blk) begin
            phase   <= PH_PAR;
            pos     <= '0;
            rd_bank <= ~rd_bank;
          end else pos <= pos + 1'b1;
        end
        default: if (adv) begin
          if (pos == CW'(PAR_BITS - 1)) begin
            phase <= full_nxt[rd_bank] ? PH_MARK : PH_IDLE;
            pos   <= '0;
          end else pos <= pos + 1'b1;
        end
      endcase
    end
  end

  AST_SOP_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_tag == PH_MARK) && out_valid); // R4
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && (out_tag == PH_MARK || out_tag == PH_PAY))
      |=> $stable(out_bit) && $stable(out_tag)); // R6
  AST_UNDERRUN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (out_tag == PH_PAR) && !out_valid && !adv); // R8
  AST_MARK_THEN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && out_tag == PH_MARK) |=> (out_tag == PH_MARK || out_tag == PH_PAY)); // R2
  AST_PARITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (par_valid && par_ready) |-> out_valid && (out_bit == par_bit)); // R7
  AST_NO_INPUT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |-> (bank_full == 2'b11)); // R9

endmodule

// File: tb/sync_block_framer_tb.sv
module sync_block_framer_tb;
  localparam int PAY = 16;
  localparam int PAR = 8;
  localparam int SUB = 64;
  localparam logic [63:0] A = 64'hFCB88938D8D76A4F;

  logic clk = 0, rst_n = 0;
  logic in_bit = 0, in_valid = 0, par_bit = 0, par_valid = 0, out_ready = 0;
  logic in_ready, par_ready, out_bit, out_valid, out_sop, underrun;
  logic [1:0] out_tag;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_block_framer #(.PAY_BITS(PAY), .PAR_BITS(PAR), .SUB_BITS(SUB), .WORD_BITS(4), .MARK_SUB(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid), .in_ready(in_ready),
    .par_bit(par_bit), .par_valid(par_valid), .par_ready(par_ready), .out_ready(out_ready),
    .out_bit(out_bit), .out_valid(out_valid), .out_sop(out_sop), .out_tag(out_tag), .underrun(underrun));

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int m_ph = 0, m_pos = 0, m_full = 0, m_wcnt = 0;
  bit pay_q[$];

  function automatic bit marker_at(int k);
    return A[SUB - 1 - (k % SUB)] ^ ((k / SUB) == 2);
  endfunction

  int phase_id = 0;
  int gaps_a = 0;
  bit steady_a = 0;
  int first_cnt = 0;
  logic [15:0] first_bits = '0;
  int pre_valid = 0;

  task automatic cycle(bit iv, bit ib, bit pv, bit pb, bit orr);
    bit e_valid, e_bit, e_sop, e_inr, e_parr, e_und, adv, acc, set_b, rel;
    string rq;
    @(negedge clk);
    in_valid = iv; in_bit = ib; par_valid = pv; par_bit = pb; out_ready = orr;
    #1;
    e_valid = (m_ph == 1) || (m_ph == 2) || (m_ph == 3 && pv);
    e_bit   = (m_ph == 1) ? marker_at(m_pos) : (m_ph == 2) ? pay_q[0] : (m_ph == 3) ? pb : 1'b0;
    e_sop   = (m_ph == 1) && (m_pos == 0);
    e_inr   = (m_full < 2);
    e_parr  = (m_ph == 3) && orr;
    e_und   = (m_ph == 3) && orr && !pv;
    rq = orr ? "R2" : "R6";
    chk(out_tag == 2'(m_ph), "R5 tag", out_tag, m_ph);
    chk(out_valid == e_valid, (m_ph == 0) ? "R11 valid" : "R7 valid", out_valid, e_valid);
    if (e_valid) chk(out_bit == e_bit, (m_ph == 1) ? "R3 marker bit" : rq, out_bit, e_bit);
    chk(out_sop == e_sop, "R4 sop", out_sop, e_sop);
    chk(in_ready == e_inr, "R9 in_ready", in_ready, e_inr);
    chk(par_ready == e_parr, "R7 par_ready", par_ready, e_parr);
    chk(underrun == e_und, "R8 underrun", underrun, e_und);
    adv = e_valid && orr;
    if (phase_id == 0 && out_valid) pre_valid++;
    if (phase_id == 1) begin
      if (e_sop) steady_a = 1;
      if (steady_a && !out_valid) gaps_a++;
    end
    if (adv && first_cnt < 16) begin
      first_bits = {first_bits[14:0], out_bit};
      first_cnt++;
    end
    acc = iv && e_inr; set_b = 0; rel = 0;
    if (acc) begin
      pay_q.push_back(ib);
      m_wcnt++;
      if (m_wcnt == PAY) begin m_wcnt = 0; set_b = 1; end
    end
    case (m_ph)
      0: if (m_full > 0) begin m_ph = 1; m_pos = 0; end
      1: if (adv) begin if (m_pos == 4*SUB - 1) begin m_ph = 2; m_pos = 0; end else m_pos++; end
      2: if (adv) begin
           void'(pay_q.pop_front());
           if (m_pos == PAY - 1) begin rel = 1; m_ph = 3; m_pos = 0; end else m_pos++;
         end
      default: if (adv) begin
           if (m_pos == PAR - 1) begin m_ph = (m_full + int'(set_b) > 0) ? 1 : 0; m_pos = 0; end
           else m_pos++;
         end
    endcase
    m_full = m_full + int'(set_b) - int'(rel);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(17));
    #1;
    chk(out_valid == 0 && out_tag == 0 && out_sop == 0 && underrun == 0, "R1 reset outputs", out_valid, 0);
    chk(in_ready == 1 && par_ready == 0, "R1 reset ready", in_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase_id = 0;
    for (int i = 0; i < 20; i++) cycle(0, 0, 1, 0, 1);
    chk(pre_valid == 0, "R11 no packet before block", pre_valid, 0);
    for (int i = 0; i < 10; i++) cycle(1, 1'($urandom), 1, 0, 1);
    chk(pre_valid == 0, "R11 partial block", pre_valid, 0);
    phase_id = 1;
    for (int i = 0; i < 1500; i++) cycle(1, 1'($urandom), 1, 1'($urandom), 1);
    chk(first_bits == 16'b1111110010111000, "R3 opening pattern", first_bits, 16'hFCB8);
    chk(gaps_a == 0, "R10 back-to-back gaps", gaps_a, 0);
    phase_id = 2;
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 10) < 6, 1'($urandom), ($urandom % 10) < 7, 1'($urandom), ($urandom % 4) != 0);
    phase_id = 3;
    for (int i = 0; i < 1200; i++) cycle(0, 0, 1, 1'($urandom), 1);
    chk(out_valid == 0 && out_tag == 0, "R11 drained idle", out_tag, 0);
    chk(pay_q.size() == m_wcnt, "R9 all payload sent", pay_q.size(), m_wcnt);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule